// File: doc/BRIEF.md
# 802.1Q Tag Stripper and Inserter

This block sits in a byte-wide Ethernet frame path and handles 802.1Q tags in both directions. The receive path watches each frame for a tag that follows the two address fields. When it finds one, it removes the four tag bytes from the stream. Alongside the last byte of the frame it reports whether a tag was present, the priority, CFI and VLAN ID the tag carried, and the number of bytes it emitted. That count includes the trailing CRC and leaves out the removed tag.

The transmit path takes a per-frame insert enable together with a priority, CFI, VLAN ID and the supplied frame byte count. When insertion is enabled, it places a four-byte tag right after the address fields and stalls its upstream side while the tag leaves. Alongside the last byte it reports whether a tag went out and the adjusted byte count.

Both streams use a valid/ready handshake with a last marker, in the manner of AXI4-Stream. CRC bytes pass through as ordinary data. They are neither generated nor checked.

Top module: `vlan_tag_unit`

## Requirements
- R1: After reset both output streams are idle (valid low) and every reported sideband field reads zero.
- R2: A receive frame whose bytes 12 and 13 are 0x81 and 0x00 leaves without bytes 12 to 15. Every other byte leaves in its original order with its value unchanged.
- R3: For such a tagged receive frame, the tagged flag reads 1. Priority is byte 14 bits 7:5, CFI is byte 14 bit 4, and the VLAN ID is byte 14 bits 3:0 followed by byte 15.
- R4: A receive frame without that pattern leaves unchanged. Its tagged flag, priority, CFI and VLAN ID read 0.
- R5: The reported 16-bit receive length equals the number of bytes emitted for the frame. That is all input bytes, CRC included, minus 4 when a tag was removed.
- R6: Reported sideband values take their new values while the last output byte of a frame is presented. They hold until the last byte of the next frame.
- R7: With insertion enabled, the transmit output carries bytes 0x81, 0x00, {priority, CFI, VLAN ID bits 11:8} and VLAN ID bits 7:0 right after input byte 11. Every input byte leaves unchanged and in order.
- R8: With insertion disabled, the transmit frame leaves byte for byte unchanged and the reported tag flag reads 0.
- R9: While the four tag bytes are emitted, transmit input ready stays low. Exactly four such stall cycles occur per tagged frame while the output is ready, and none occur for an untagged frame.
- R10: The reported transmit length is the supplied per-frame length plus 4 when a tag was inserted, and the supplied length otherwise.
- R11: On either output, a byte offered while ready is low stays on the output, unchanged and still valid, until it is accepted.
- R12: Transmit sideband inputs are taken on the first byte of a frame. Changes to them later in that frame do not affect its output bytes or its reported values.
- R13: A receive frame whose byte 12 is 0x81 but whose byte 13 is not 0x00 is treated as untagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in_data | input | 8 | Receive stream byte in |
| rx_in_valid | input | 1 | Receive input byte valid |
| rx_in_last | input | 1 | Receive input byte ends the frame |
| rx_in_ready | output | 1 | Receive input byte accepted |
| rx_out_data | output | 8 | Receive stream byte out, tag removed |
| rx_out_valid | output | 1 | Receive output byte valid |
| rx_out_last | output | 1 | Receive output byte ends the frame |
| rx_out_ready | input | 1 | Downstream accepts receive byte |
| rx_tagged | output | 1 | Frame carried an 802.1Q tag |
| rx_pcp | output | 3 | Priority from the tag |
| rx_cfi | output | 1 | CFI from the tag |
| rx_vid | output | 12 | VLAN ID from the tag |
| rx_len | output | 16 | Emitted receive bytes, CRC included |
| tx_in_data | input | 8 | Transmit stream byte in |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_last | input | 1 | Transmit input byte ends the frame |
| tx_in_ready | output | 1 | Transmit input byte accepted |
| tx_ins_en | input | 1 | Insert a tag into this frame |
| tx_pcp | input | 3 | Priority to insert |
| tx_cfi | input | 1 | CFI to insert |
| tx_vid | input | 12 | VLAN ID to insert |
| tx_len_in | input | 16 | Supplied frame byte count |
| tx_out_data | output | 8 | Transmit stream byte out |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_last | output | 1 | Transmit output byte ends the frame |
| tx_out_ready | input | 1 | Downstream accepts transmit byte |
| tx_tagged | output | 1 | A tag was inserted in this frame |
| tx_len_out | output | 16 | Supplied count, plus 4 if tagged |

## Verification
The embedded properties assume that upstream obeys the handshake. A valid byte stays on the input with the same data and last marker until it is accepted. They also assume that a one-byte frame never follows directly after a frame end, and that a tagged receive frame carries at least one byte beyond its tag. The stimulus keeps within this. Input valid drops only after acceptance, and data changes only on the falling edge after a handshake. Every frame is at least 18 bytes long. Backpressure comes from the output ready pattern alone.

// File: rtl/vtag_pkg.sv
`timescale 1ns/1ps
// Shared types for the 802.1Q tag stripper/inserter.
// Assumes byte-wide streams; the tag control word layout is fixed by 802.1Q.
package vtag_pkg;
    localparam int BYTE_W = 8;
    localparam int TAG_BYTES = 4;

    typedef struct packed {
        logic [2:0]  pcp;
        logic        cfi;
        logic [11:0] vid;
    } tci_t;

    typedef enum logic [2:0] {
        RX_HEAD,
        RX_GRAB,
        RX_FLUSH,
        RX_TCI,
        RX_BODY
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_HEAD,
        TX_TAG,
        TX_BODY
    } tx_state_e;
endpackage

// File: rtl/vtag_len_count.sv
`timescale 1ns/1ps
// Saturating per-frame byte counter.
// Counts one per step; a step flagged as clear restarts from zero.
// next_cnt is the count including the byte being stepped now.
module vtag_len_count #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    output logic [LEN_W-1:0] next_cnt
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt;

    // saturating increment of the running count
    assign next_cnt = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

    // hold the count of bytes already stepped in this frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= clear ? '0 : next_cnt;
    end
endmodule

// File: rtl/vtag_rx_strip.sv
`timescale 1ns/1ps
// Receive tag stripper.
// Passes the address bytes straight through, then holds the next two bytes.
// If they match the tag identifier, it swallows them and the two control
// bytes; otherwise it replays them. Reports tag fields and emitted length
// alongside the last output byte.
// Assumes upstream holds a valid byte until accepted and that a tagged
// frame carries at least one byte after the tag.
module vtag_rx_strip
    import vtag_pkg::*;
#(
    parameter int          HDR_BYTES = 12,
    parameter int          LEN_W     = 16,
    parameter logic [15:0] TPID      = 16'h8100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready,
    output logic              info_tagged,
    output tci_t              info_tci,
    output logic [LEN_W-1:0]  info_len
);
    localparam int POS_W = $clog2(HDR_BYTES + 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(HDR_BYTES - 1);

    rx_state_e         st;
    logic [POS_W-1:0]  pos;
    logic              sub;
    logic [BYTE_W-1:0] hold0, hold1, tci_hi;
    logic              flush_idx, flush_end, flush_last;
    logic              cur_tag, pub_tag;
    tci_t              cur_tci, pub_tci;
    logic [LEN_W-1:0]  pub_len, live_len;
    logic              in_hs, out_hs, frame_end, show_live;

    assign in_hs     = s_valid && s_ready;
    assign out_hs    = m_valid && m_ready;
    assign frame_end = out_hs && m_last;
    assign show_live = m_valid && m_last;

    // steer the streams according to the current phase of the frame
    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_data  = s_data;
        m_last  = s_last;
        unique case (st)
            RX_HEAD, RX_BODY: begin
                s_ready = m_ready;
                m_valid = s_valid;
            end
            RX_GRAB, RX_TCI: s_ready = 1'b1;
            RX_FLUSH: begin
                m_valid = 1'b1;
                m_data  = flush_idx ? hold1 : hold0;
                m_last  = flush_last && (flush_idx == flush_end);
            end
            default: ;
        endcase
    end

    // frame phase sequencing and holding of the candidate tag bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= RX_HEAD;
            pos        <= '0;
            sub        <= 1'b0;
            hold0      <= '0;
            hold1      <= '0;
            tci_hi     <= '0;
            flush_idx  <= 1'b0;
            flush_end  <= 1'b0;
            flush_last <= 1'b0;
        end else begin
            unique case (st)
                RX_HEAD: if (in_hs) begin
                    if (s_last)
                        pos <= '0;
                    else if (pos == POS_END) begin
                        pos <= '0;
                        sub <= 1'b0;
                        st  <= RX_GRAB;
                    end else
                        pos <= pos + 1'b1;
                end
                RX_GRAB: if (s_valid) begin
                    if (!sub) begin
                        hold0 <= s_data;
                        if (s_last) begin
                            flush_idx  <= 1'b0;
                            flush_end  <= 1'b0;
                            flush_last <= 1'b1;
                            st         <= RX_FLUSH;
                        end else
                            sub <= 1'b1;
                    end else begin
                        hold1 <= s_data;
                        sub   <= 1'b0;
                        if (hold0 == TPID[15:8] && s_data == TPID[7:0] && !s_last)
                            st <= RX_TCI;
                        else begin
                            flush_idx  <= 1'b0;
                            flush_end  <= 1'b1;
                            flush_last <= s_last;
                            st         <= RX_FLUSH;
                        end
                    end
                end
                RX_FLUSH: if (m_ready) begin
                    if (flush_idx == flush_end)
                        st <= flush_last ? RX_HEAD : RX_BODY;
                    else
                        flush_idx <= 1'b1;
                end
                RX_TCI: if (s_valid) begin
                    if (!sub) begin
                        tci_hi <= s_data;
                        sub    <= 1'b1;
                    end else begin
                        sub <= 1'b0;
                        st  <= RX_BODY;
                    end
                end
                RX_BODY: if (frame_end) st <= RX_HEAD;
                default: st <= RX_HEAD;
            endcase
        end
    end

    // capture the tag fields of the frame in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tag <= 1'b0;
            cur_tci <= '0;
        end else if (frame_end) begin
            cur_tag <= 1'b0;
            cur_tci <= '0;
        end else if (st == RX_TCI && s_valid && sub) begin
            cur_tag <= 1'b1;
            cur_tci <= tci_t'({tci_hi, s_data});
        end
    end

    // count emitted bytes of the frame
    vtag_len_count #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (out_hs),
        .clear    (frame_end),
        .next_cnt (live_len)
    );

    // publish the finished frame's report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_tag <= 1'b0;
            pub_tci <= '0;
            pub_len <= '0;
        end else if (frame_end) begin
            pub_tag <= cur_tag;
            pub_tci <= cur_tci;
            pub_len <= live_len;
        end
    end

    assign info_tagged = show_live ? cur_tag  : pub_tag;
    assign info_tci    = show_live ? cur_tci  : pub_tci;
    assign info_len    = show_live ? live_len : pub_len;

    // R11
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R4
    rx_untag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !info_tagged |-> (info_tci == '0));

    // R6
    rx_info_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> ((m_valid && m_last) ||
                       (info_len == $past(info_len) && info_tagged == $past(info_tagged))));
endmodule

// File: rtl/vtag_tx_insert.sv
`timescale 1ns/1ps
// Transmit tag inserter.
// Takes the per-frame sideband on the first byte, passes the address bytes,
// then, if enabled, emits the four tag bytes while holding upstream off.
// Reports the tag flag and adjusted length alongside the last output byte.
// Assumes upstream holds a valid byte until accepted; a frame that ends
// within the address bytes leaves untagged.
module vtag_tx_insert
    import vtag_pkg::*;
#(
    parameter int          HDR_BYTES = 12,
    parameter int          LEN_W     = 16,
    parameter logic [15:0] TPID      = 16'h8100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              sb_ins,
    input  tci_t              sb_tci,
    input  logic [LEN_W-1:0]  sb_len,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready,
    output logic              info_tagged,
    output logic [LEN_W-1:0]  info_len
);
    localparam int POS_W = $clog2(HDR_BYTES + 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(HDR_BYTES - 1);
    localparam logic [LEN_W-1:0] TAG_LEN = LEN_W'(TAG_BYTES);

    tx_state_e        st;
    logic [POS_W-1:0] pos;
    logic [1:0]       tag_idx;
    logic             lat_ins, eff_ins, first_byte;
    tci_t             lat_tci, eff_tci;
    logic [LEN_W-1:0] lat_len, eff_len, pub_len, live_len;
    logic             cur_tag, pub_tag;
    logic             in_hs, out_hs, frame_end, show_live, start_tag;
    logic [15:0]      tci_word;
    logic [BYTE_W-1:0] tag_byte;

    assign in_hs      = s_valid && s_ready;
    assign out_hs     = m_valid && m_ready;
    assign frame_end  = out_hs && m_last;
    assign show_live  = m_valid && m_last;
    assign first_byte = (st == TX_HEAD) && (pos == '0);

    // use the live sideband on the first byte, the latched copy afterwards
    always_comb begin
        eff_ins = first_byte ? sb_ins : lat_ins;
        eff_tci = first_byte ? sb_tci : lat_tci;
        eff_len = first_byte ? sb_len : lat_len;
    end

    assign start_tag = (st == TX_HEAD) && in_hs && (pos == POS_END) && !s_last && eff_ins;
    assign tci_word  = eff_tci;

    // pick the tag byte for the current slot
    always_comb begin
        unique case (tag_idx)
            2'd0:    tag_byte = TPID[15:8];
            2'd1:    tag_byte = TPID[7:0];
            2'd2:    tag_byte = tci_word[15:8];
            default: tag_byte = tci_word[7:0];
        endcase
    end

    // steer the streams according to the current phase of the frame
    always_comb begin
        s_ready = m_ready;
        m_valid = s_valid;
        m_data  = s_data;
        m_last  = s_last;
        if (st == TX_TAG) begin
            s_ready = 1'b0;
            m_valid = 1'b1;
            m_data  = tag_byte;
            m_last  = 1'b0;
        end
    end

    // frame phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_HEAD;
            pos     <= '0;
            tag_idx <= '0;
        end else begin
            unique case (st)
                TX_HEAD: if (in_hs) begin
                    if (s_last)
                        pos <= '0;
                    else if (pos == POS_END) begin
                        pos     <= '0;
                        tag_idx <= '0;
                        st      <= eff_ins ? TX_TAG : TX_BODY;
                    end else
                        pos <= pos + 1'b1;
                end
                TX_TAG: if (m_ready) begin
                    if (tag_idx == 2'(TAG_BYTES - 1))
                        st <= TX_BODY;
                    else
                        tag_idx <= tag_idx + 1'b1;
                end
                TX_BODY: if (frame_end) st <= TX_HEAD;
                default: st <= TX_HEAD;
            endcase
        end
    end

    // latch the sideband on the first accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_ins <= 1'b0;
            lat_tci <= '0;
            lat_len <= '0;
        end else if (first_byte && in_hs) begin
            lat_ins <= sb_ins;
            lat_tci <= sb_tci;
            lat_len <= sb_len;
        end
    end

    // remember whether this frame received a tag
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_tag <= 1'b0;
        else if (frame_end)
            cur_tag <= 1'b0;
        else if (start_tag)
            cur_tag <= 1'b1;
    end

    assign live_len = eff_len + (cur_tag ? TAG_LEN : '0);

    // publish the finished frame's report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_tag <= 1'b0;
            pub_len <= '0;
        end else if (frame_end) begin
            pub_tag <= cur_tag;
            pub_len <= live_len;
        end
    end

    assign info_tagged = show_live ? cur_tag  : pub_tag;
    assign info_len    = show_live ? live_len : pub_len;

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R7
    tx_tag_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_tag |=> (m_valid && m_data == TPID[15:8] && !m_last));

    // R9
    tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_tag |=> !s_ready);
endmodule

// File: rtl/vlan_tag_unit.sv
`timescale 1ns/1ps
// 802.1Q tag handling for a byte-wide Ethernet path.
// Receive side strips a tag after the address bytes and reports its fields;
// transmit side inserts a tag on request per frame. The two directions are
// independent and share only clock and reset.
module vlan_tag_unit
    import vtag_pkg::*;
#(
    parameter int          HDR_BYTES = 12,
    parameter int          LEN_W     = 16,
    parameter logic [15:0] TPID      = 16'h8100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_in_data,
    input  logic             rx_in_valid,
    input  logic             rx_in_last,
    output logic             rx_in_ready,
    output logic [7:0]       rx_out_data,
    output logic             rx_out_valid,
    output logic             rx_out_last,
    input  logic             rx_out_ready,
    output logic             rx_tagged,
    output logic [2:0]       rx_pcp,
    output logic             rx_cfi,
    output logic [11:0]      rx_vid,
    output logic [LEN_W-1:0] rx_len,
    input  logic [7:0]       tx_in_data,
    input  logic             tx_in_valid,
    input  logic             tx_in_last,
    output logic             tx_in_ready,
    input  logic             tx_ins_en,
    input  logic [2:0]       tx_pcp,
    input  logic             tx_cfi,
    input  logic [11:0]      tx_vid,
    input  logic [LEN_W-1:0] tx_len_in,
    output logic [7:0]       tx_out_data,
    output logic             tx_out_valid,
    output logic             tx_out_last,
    input  logic             tx_out_ready,
    output logic             tx_tagged,
    output logic [LEN_W-1:0] tx_len_out
);
    tci_t rx_tci, tx_tci;

    // gather the transmit tag fields into one control word
    always_comb begin
        tx_tci.pcp = tx_pcp;
        tx_tci.cfi = tx_cfi;
        tx_tci.vid = tx_vid;
    end

    assign rx_pcp = rx_tci.pcp;
    assign rx_cfi = rx_tci.cfi;
    assign rx_vid = rx_tci.vid;

    vtag_rx_strip #(.HDR_BYTES(HDR_BYTES), .LEN_W(LEN_W), .TPID(TPID)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_data      (rx_in_data),
        .s_valid     (rx_in_valid),
        .s_last      (rx_in_last),
        .s_ready     (rx_in_ready),
        .m_data      (rx_out_data),
        .m_valid     (rx_out_valid),
        .m_last      (rx_out_last),
        .m_ready     (rx_out_ready),
        .info_tagged (rx_tagged),
        .info_tci    (rx_tci),
        .info_len    (rx_len)
    );

    vtag_tx_insert #(.HDR_BYTES(HDR_BYTES), .LEN_W(LEN_W), .TPID(TPID)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_data      (tx_in_data),
        .s_valid     (tx_in_valid),
        .s_last      (tx_in_last),
        .s_ready     (tx_in_ready),
        .sb_ins      (tx_ins_en),
        .sb_tci      (tx_tci),
        .sb_len      (tx_len_in),
        .m_data      (tx_out_data),
        .m_valid     (tx_out_valid),
        .m_last      (tx_out_last),
        .m_ready     (tx_out_ready),
        .info_tagged (tx_tagged),
        .info_len    (tx_len_out)
    );

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_out_valid && !tx_out_valid && rx_len == '0 && tx_len_out == '0));
endmodule

// File: tb/vlan_tag_unit_tb.sv
`timescale 1ns/1ps
module vlan_tag_unit_tb;
    typedef struct packed {
        logic        dir;   // 0 receive, 1 transmit
        logic [1:0]  mark;  // rx: 0 none, 1 tag, 2 partial; tx: bit0 insert
        logic        bp;
        logic        chg;
        logic [7:0]  len;
        logic [15:0] tci;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        vec_t'{1'b0, 2'd1, 1'b0, 1'b0, 8'd40, 16'hA123, 8'h11},
        vec_t'{1'b0, 2'd0, 1'b1, 1'b0, 8'd30, 16'h0000, 8'h22},
        vec_t'{1'b0, 2'd1, 1'b1, 1'b0, 8'd64, 16'hFFFF, 8'h33},
        vec_t'{1'b0, 2'd2, 1'b0, 1'b0, 8'd20, 16'h0000, 8'h44},
        vec_t'{1'b0, 2'd1, 1'b0, 1'b0, 8'd18, 16'h2005, 8'h55},
        vec_t'{1'b1, 2'd1, 1'b0, 1'b0, 8'd40, 16'h6ABC, 8'h66},
        vec_t'{1'b1, 2'd0, 1'b1, 1'b0, 8'd25, 16'h1234, 8'h77},
        vec_t'{1'b1, 2'd1, 1'b1, 1'b0, 8'd64, 16'h0001, 8'h88},
        vec_t'{1'b1, 2'd1, 1'b0, 1'b1, 8'd30, 16'hE555, 8'h99},
        vec_t'{1'b1, 2'd0, 1'b0, 1'b1, 8'd28, 16'h3333, 8'h10}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_in_data = '0, tx_in_data = '0;
    logic rx_in_valid = 1'b0, rx_in_last = 1'b0, rx_out_ready = 1'b0;
    logic tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b0;
    logic tx_ins_en = 1'b0, tx_cfi = 1'b0;
    logic [2:0] tx_pcp = '0;
    logic [11:0] tx_vid = '0;
    logic [15:0] tx_len_in = '0;
    logic rx_in_ready, rx_out_valid, rx_out_last, rx_tagged, rx_cfi;
    logic [7:0] rx_out_data, tx_out_data;
    logic [2:0] rx_pcp;
    logic [11:0] rx_vid;
    logic [15:0] rx_len, tx_len_out;
    logic tx_in_ready, tx_out_valid, tx_out_last, tx_tagged;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vlan_tag_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_last(rx_in_last),
        .rx_in_ready(rx_in_ready), .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid),
        .rx_out_last(rx_out_last), .rx_out_ready(rx_out_ready), .rx_tagged(rx_tagged),
        .rx_pcp(rx_pcp), .rx_cfi(rx_cfi), .rx_vid(rx_vid), .rx_len(rx_len),
        .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
        .tx_in_ready(tx_in_ready), .tx_ins_en(tx_ins_en), .tx_pcp(tx_pcp), .tx_cfi(tx_cfi),
        .tx_vid(tx_vid), .tx_len_in(tx_len_in), .tx_out_data(tx_out_data),
        .tx_out_valid(tx_out_valid), .tx_out_last(tx_out_last), .tx_out_ready(tx_out_ready),
        .tx_tagged(tx_tagged), .tx_len_out(tx_len_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [7:0] ib [0:71];
        logic [7:0] eb [0:71];
        logic [7:0] ob [0:71];
        int n = v.len, en = 0, ii = 0, oi = 0, cyc = 0, stall = 0, bad = 0, bad_at = -1;
        bit done = 0, flipped = 0, ins, tagged_exp;
        logic s_tag, s_cfi;
        logic [2:0] s_pcp;
        logic [11:0] s_vid;
        logic [15:0] s_len, exp_len;
        string rs, rl;

        for (int i = 0; i < n; i++) ib[i] = v.seed + 8'(i * 13);
        if (!v.dir) begin
            unique case (v.mark)
                2'd1: begin ib[12] = 8'h81; ib[13] = 8'h00; ib[14] = v.tci[15:8]; ib[15] = v.tci[7:0]; end
                2'd2: begin ib[12] = 8'h81; ib[13] = 8'h01; end
                default: begin ib[12] = 8'h08; ib[13] = 8'h00; end
            endcase
        end
        ins = v.dir && v.mark[0];
        tagged_exp = v.dir ? ins : (v.mark == 2'd1);
        for (int i = 0; i < n; i++) begin
            if (!v.dir && tagged_exp && i >= 12 && i <= 15) continue;
            if (ins && i == 12) begin
                eb[en] = 8'h81; eb[en+1] = 8'h00; eb[en+2] = v.tci[15:8]; eb[en+3] = v.tci[7:0];
                en += 4;
            end
            eb[en] = ib[i];
            en++;
        end
        exp_len = v.dir ? 16'(n + (ins ? 4 : 0)) : 16'(en);

        if (v.dir) begin
            tx_ins_en = v.mark[0]; tx_pcp = v.tci[15:13]; tx_cfi = v.tci[12];
            tx_vid = v.tci[11:0]; tx_len_in = 16'(n);
        end

        while (!done) begin
            @(negedge clk);
            if (v.chg && ii >= 1 && !flipped) begin
                flipped = 1;
                tx_ins_en = ~tx_ins_en; tx_vid = ~tx_vid; tx_pcp = ~tx_pcp; tx_len_in = tx_len_in + 16'd7;
            end
            if (v.dir) begin
                tx_in_valid = (ii < n); tx_in_data = (ii < n) ? ib[ii] : 8'h00; tx_in_last = (ii == n - 1);
                tx_out_ready = v.bp ? (cyc % 3 != 2) : 1'b1;
            end else begin
                rx_in_valid = (ii < n); rx_in_data = (ii < n) ? ib[ii] : 8'h00; rx_in_last = (ii == n - 1);
                rx_out_ready = v.bp ? (cyc % 3 != 2) : 1'b1;
            end
            #1;
            if (v.dir) begin
                if (tx_out_ready && tx_in_valid && !tx_in_ready) stall++;
                if (tx_in_valid && tx_in_ready) ii++;
                if (tx_out_valid && tx_out_ready) begin
                    ob[oi] = tx_out_data; oi++;
                    if (tx_out_last) begin done = 1; s_tag = tx_tagged; s_len = tx_len_out; end
                end
            end else begin
                if (rx_in_valid && rx_in_ready) ii++;
                if (rx_out_valid && rx_out_ready) begin
                    ob[oi] = rx_out_data; oi++;
                    if (rx_out_last) begin
                        done = 1; s_tag = rx_tagged; s_pcp = rx_pcp; s_cfi = rx_cfi;
                        s_vid = rx_vid; s_len = rx_len;
                    end
                end
            end
            cyc++;
            if (oi > 70 || cyc > 2000) begin
                check(0, "R2", $sformatf("vector %0d timeout", idx), cyc, 0);
                break;
            end
        end
        @(negedge clk);
        rx_in_valid = 0; tx_in_valid = 0; rx_in_last = 0; tx_in_last = 0;

        if (v.dir) rs = v.chg ? "R12" : (ins ? (v.bp ? "R7/R11" : "R7") : (v.bp ? "R8/R11" : "R8"));
        else rs = v.mark == 2'd2 ? "R13" : (tagged_exp ? (v.bp ? "R2/R11" : "R2") : (v.bp ? "R4/R11" : "R4"));
        rl = v.dir ? (v.chg ? "R12" : "R10") : "R5";

        check(oi == en, rs, $sformatf("vector %0d byte count", idx), oi, en);
        for (int i = 0; i < en && i < oi; i++)
            if (ob[i] !== eb[i]) begin bad++; if (bad_at < 0) bad_at = i; end
        check(bad == 0, rs, $sformatf("vector %0d byte %0d", idx, bad_at),
              bad_at < 0 ? 0 : int'(ob[bad_at]), bad_at < 0 ? 0 : int'(eb[bad_at]));
        check(s_tag == tagged_exp, v.dir ? (v.chg ? "R12" : "R8") : "R3",
              $sformatf("vector %0d tagged flag", idx), s_tag, tagged_exp);
        check(s_len == exp_len, rl, $sformatf("vector %0d length", idx), s_len, exp_len);
        if (v.dir) begin
            check(stall == (ins ? 4 : 0), "R9", $sformatf("vector %0d stall cycles", idx), stall, ins ? 4 : 0);
        end else begin
            check({s_pcp, s_cfi, s_vid} == (tagged_exp ? v.tci : 16'h0000), tagged_exp ? "R3" : "R4",
                  $sformatf("vector %0d tag fields", idx), {s_pcp, s_cfi, s_vid}, tagged_exp ? v.tci : 16'h0);
        end
        repeat (4) @(negedge clk);
        #1;
        if (v.dir)
            check(tx_tagged == s_tag && tx_len_out == s_len, "R6",
                  $sformatf("vector %0d held tx report", idx), tx_len_out, s_len);
        else
            check(rx_tagged == s_tag && rx_len == s_len && rx_vid == s_vid, "R6",
                  $sformatf("vector %0d held rx report", idx), rx_len, s_len);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(!rx_out_valid && !tx_out_valid, "R1", "outputs idle", {rx_out_valid, tx_out_valid}, 0);
        check(rx_len == 0 && tx_len_out == 0 && !rx_tagged && !tx_tagged && rx_vid == 0 && rx_pcp == 0,
              "R1", "sideband zero", rx_len, 0);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
        // R6: report changes only at the next frame end; directed reset then clears it (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check(rx_len == 0 && tx_len_out == 0 && !tx_tagged, "R1", "report cleared by reset", tx_len_out, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule